// File: doc/BRIEF.md
# Serial ADC capture controller

This controller sits on the host side of a 12-bit serial converter. From the system clock it makes the serial clock and a conversion-start strobe, and it repeats a frame of 16 serial-clock periods for as long as `run` is high. In each frame it reads 13 bits from the converter's data line. The first bit tells whether the converter's reference has settled. The other twelve are the conversion result, most significant bit first. At the end of the frame the controller gives out the word, the reference flag and a one-cycle valid strobe.

Two single-cycle request inputs put the converter into its low-power sleep state and bring it back out. Each request is acted on only at a frame boundary. Sleep is entered by sending conversion-start pulses with the serial clock held low. Wake is done by sending one serial-clock pulse with no conversion start.

Top module: `adc_capture_ctrl`

## Requirements
- R1: Every conversion-start pulse is high for exactly DIV system clocks, which is one serial-clock period. In a normal frame it rises on the same clock as a serial-clock rising edge.
- R2: The serial clock has a period of DIV system clocks and is high for DIV/2 of them. While `run` stays high, consecutive frame starts are 16*DIV system clocks apart.
- R3: Serial-clock rising edges are numbered 0 to 15 from the frame start, where edge 0 rises together with the conversion start. The bit the converter drives after edge 2 is captured as the reference flag. The bits driven after edges 3 to 14 are captured as result bits 11 down to 0.
- R4: `result_valid` is high for exactly one system clock per completed frame. `result` and `ref_flag` change only on that clock and hold their values until the next completed frame.
- R5: `ref_not_ready` is 0 after reset. On each completed frame it is set to the inverse of the captured reference flag, so it is 1 while the last captured flag was 0. The result word is delivered in either case.
- R6: A sleep request produces four conversion-start pulses, two serial periods apart, with no serial-clock edge. `asleep` then goes to 1. While asleep, no pulse appears on either line, even with `run` high, and further sleep requests are ignored.
- R7: A wake request while asleep produces exactly one serial-clock pulse and no conversion start, then clears `asleep`. After that, frames resume when `run` is high. A wake request while awake produces no output activity.
- R8: A sleep or wake request that arrives mid-frame waits. The current frame completes and delivers its result first.
- R9: While reset is active, `adc_sck`, `adc_cnv`, `result`, `ref_flag`, `result_valid`, `ref_not_ready` and `asleep` are all 0.
- R10: When `run` goes low, no new frame starts, but a frame that has already started runs to completion and delivers its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep starting frames while high |
| sleep_req | input | 1 | One-cycle request to put the converter to sleep |
| wake_req | input | 1 | One-cycle request to wake the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_cnv | output | 1 | Conversion-start strobe to the converter |
| result | output | DATA_W | Last captured conversion word |
| ref_flag | output | 1 | Reference flag captured with `result` |
| result_valid | output | 1 | One-cycle strobe when a new word is ready |
| ref_not_ready | output | 1 | Set while the last captured reference flag was low |
| asleep | output | 1 | Converter has been placed in sleep |

## Verification
A behavioural converter model in the bench counts serial-clock edges from each conversion start and drives known words, so any off-by-one in the sampling point shows up as a result shifted by one bit with the reference flag mixed into the data. The bench sends a sleep request in the middle of a frame. A controller that acts on it at once would cut the frame short and lose that result. The bench also counts the pulses of the sleep and wake sequences. A stray serial-clock edge between sleep pulses would keep the converter awake, and a conversion start during wake would begin a frame nobody reads. Stopping `run` mid-frame must still give one last word, and a valid strobe held longer than one cycle would be counted twice.

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
  parameter int DIV          = 4,
  parameter int DATA_W       = 12,
  parameter int FRAME        = 16,
  parameter int SLEEP_PULSES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic              adc_sdo,
  output logic              adc_sck,
  output logic              adc_cnv,
  output logic [DATA_W-1:0] result,
  output logic              ref_flag,
  output logic              result_valid,
  output logic              ref_not_ready,
  output logic              asleep
);

  localparam int HALF    = DIV / 2;
  localparam int CW      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int KW      = $clog2(FRAME);
  localparam int FIRST   = 3;
  localparam int LAST    = FIRST + DATA_W;
  localparam int SLP_END = 2 * SLEEP_PULSES - 1;

  typedef enum logic [1:0] {M_IDLE, M_CONV, M_SLEEP, M_WAKE} mode_t;

  mode_t             mode, mode_n;
  logic [CW-1:0]     div_cnt;
  logic [KW-1:0]     k, k_n;
  logic              sleep_p, wake_p, clr_s, clr_w, sleepy, decide;
  logic [DATA_W-1:0] sh;

  wire slot_start = (div_cnt == CW'(DIV - 1));
  wire sck_fall   = (div_cnt == CW'(HALF - 1));
  wire cnv_n      = (mode_n == M_CONV && k_n == '0) || (mode_n == M_SLEEP && !k_n[0]);
  wire gate_n     = (mode_n == M_CONV) || (mode_n == M_WAKE);
  wire take       = slot_start && mode_n == M_CONV && k_n >= KW'(FIRST);

  always_comb begin
    mode_n = mode;
    k_n    = k + 1'b1;
    clr_s  = 1'b0;
    clr_w  = 1'b0;
    sleepy = asleep;
    decide = 1'b0;
    case (mode)
      M_CONV:  decide = (k == KW'(FRAME - 1));
      M_SLEEP: if (k == KW'(SLP_END)) begin decide = 1'b1; sleepy = 1'b1; end
      M_WAKE:  begin decide = 1'b1; sleepy = 1'b0; end
      default: decide = 1'b1;
    endcase
    if (decide) begin
      k_n = '0;
      if (sleepy) begin
        clr_s = 1'b1;
        if (wake_p) begin mode_n = M_WAKE; clr_w = 1'b1; end
        else mode_n = M_IDLE;
      end else begin
        clr_w = 1'b1;
        if (sleep_p) begin mode_n = M_SLEEP; clr_s = 1'b1; end
        else if (run) mode_n = M_CONV;
        else mode_n = M_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE; k <= '0; div_cnt <= '0;
      sleep_p <= 1'b0; wake_p <= 1'b0; asleep <= 1'b0;
      adc_sck <= 1'b0; adc_cnv <= 1'b0; sh <= '0;
      result <= '0; ref_flag <= 1'b0; ref_not_ready <= 1'b0; result_valid <= 1'b0;
    end else begin
      div_cnt      <= slot_start ? '0 : div_cnt + 1'b1;
      result_valid <= 1'b0;
      sleep_p      <= (sleep_p & ~(slot_start & clr_s)) | sleep_req;
      wake_p       <= (wake_p & ~(slot_start & clr_w)) | wake_req;
      if (slot_start) begin
        mode    <= mode_n;
        k       <= k_n;
        asleep  <= sleepy;
        adc_cnv <= cnv_n;
        adc_sck <= gate_n;
      end else if (sck_fall) begin
        adc_sck <= 1'b0;
      end
      if (take) begin
        sh <= {sh[DATA_W-2:0], adc_sdo};
        if (k_n == KW'(LAST)) begin
          result        <= {sh[DATA_W-2:0], adc_sdo};
          ref_flag      <= sh[DATA_W-1];
          ref_not_ready <= ~sh[DATA_W-1];
          result_valid  <= 1'b1;
        end
      end
    end
  end

  assert_cnv_with_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adc_cnv) && mode == M_CONV) |-> adc_sck);

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(result) && $stable(ref_flag)));

  assert_sleep_no_sck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP) |-> !adc_sck);

  assert_asleep_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && mode == M_IDLE) |-> (!adc_sck && !adc_cnv));

  assert_wake_no_cnv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WAKE) |-> !adc_cnv);

endmodule

// File: tb/adc_capture_ctrl_test.sv
module adc_capture_ctrl_test;
  localparam int DIV = 4;
  localparam int NV  = 6;
  localparam logic [12:0] VEC [NV] = '{13'h1FFF, 13'h1000, 13'h0ABC, 13'h1555, 13'h1AAA, 13'h1801};
  localparam logic [12:0] EXTRA = 13'h15C3;

  logic clk = 0, rst_n = 0, run = 0, sleep_req = 0, wake_req = 0, adc_sdo = 0;
  logic adc_sck, adc_cnv, ref_flag, result_valid, ref_not_ready, asleep;
  logic [11:0] result;

  int nchecks = 0, nfail = 0;
  int n_sck_r = 0, n_cnv_r = 0, n_valid = 0, cyc = 0, last_fs = -1;
  int cnv_hi = 0, sck_hi = 0, e = 0, fidx = 0, quiet = 0;
  logic p_sck = 0, p_cnv = 0, sck_r, cnv_r, msleep = 0, chk_period = 0;
  logic [12:0] word = '0;

  adc_capture_ctrl #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .sleep_req(sleep_req), .wake_req(wake_req),
    .adc_sdo(adc_sdo), .adc_sck(adc_sck), .adc_cnv(adc_cnv), .result(result),
    .ref_flag(ref_flag), .result_valid(result_valid), .ref_not_ready(ref_not_ready),
    .asleep(asleep));

  always #2 clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    sck_r = adc_sck && !p_sck;
    cnv_r = adc_cnv && !p_cnv;
    if (rst_n) begin
      if (result_valid) n_valid++;
      if (sck_r) n_sck_r++;
      if (cnv_r) n_cnv_r++;
      if (adc_cnv) cnv_hi++;
      else if (p_cnv) begin check(cnv_hi == DIV, "R1 cnv width", cnv_hi, DIV); cnv_hi = 0; end
      if (adc_sck) sck_hi++;
      else if (p_sck) begin check(sck_hi == DIV/2, "R2 sck high", sck_hi, DIV/2); sck_hi = 0; end
      if (cnv_r && sck_r) begin
        if (chk_period && last_fs >= 0) check(cyc - last_fs == 16*DIV, "R2 frame period", cyc - last_fs, 16*DIV);
        last_fs = cyc;
        e = 0;
        word = (fidx < NV) ? VEC[fidx] : EXTRA;
        fidx++;
      end else if (sck_r) begin
        e++;
        if (e == 2) adc_sdo = word[12];
        else if (e >= 3 && e <= 14) adc_sdo = word[14 - e];
      end
      if (sck_r) begin quiet = 0; msleep = 0; end
      else if (cnv_r) begin quiet++; if (quiet >= 4) msleep = 1; end
    end
    p_sck = adc_sck;
    p_cnv = adc_cnv;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_valid(output logic ok);
    ok = 0;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk); #1;
      if (result_valid) begin ok = 1; break; end
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) sleep_req = 1; else wake_req = 1;
    @(negedge clk);
    sleep_req = 0; wake_req = 0;
    #1;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    logic ok;
    int c0, s0, v0;
    tick(5);
    check({adc_sck, adc_cnv, result, ref_flag, result_valid, ref_not_ready, asleep} == '0,
          "R9 reset outputs", result, 0);
    rst_n = 1;
    tick(20);
    check(n_cnv_r == 0 && n_sck_r == 0, "R10 idle with run low", n_cnv_r, 0);

    chk_period = 1;
    run = 1;
    for (int i = 0; i < NV; i++) begin
      wait_valid(ok);
      check(ok, "R4 valid arrives", ok, 1);
      check(result == VEC[i][11:0], "R3 data word", result, VEC[i][11:0]);
      check(ref_flag == VEC[i][12], "R3 ref flag", ref_flag, VEC[i][12]);
      check(ref_not_ready == !VEC[i][12], "R5 not-ready", ref_not_ready, !VEC[i][12]);
      tick(1);
      check(!result_valid && result == VEC[i][11:0], "R4 single pulse and hold", result_valid, 0);
    end
    chk_period = 0;

    tick(10);
    pulse(0);
    c0 = n_cnv_r;
    wait_valid(ok);
    check(ok && result == EXTRA[11:0], "R8 frame finishes before sleep", result, EXTRA[11:0]);
    check(n_cnv_r == c0 && !msleep, "R8 no sleep pulse mid-frame", n_cnv_r - c0, 0);
    c0 = n_cnv_r; s0 = n_sck_r;
    for (int t = 0; t < 500 && !asleep; t++) tick(1);
    check(asleep, "R6 asleep set", asleep, 1);
    check(n_cnv_r - c0 == 4, "R6 four cnv pulses", n_cnv_r - c0, 4);
    check(n_sck_r - s0 == 0, "R6 no sck in sequence", n_sck_r - s0, 0);
    check(msleep, "R6 model asleep", msleep, 1);
    c0 = n_cnv_r; s0 = n_sck_r;
    pulse(0);
    tick(200);
    check(n_cnv_r == c0 && n_sck_r == s0 && asleep, "R6 quiet while asleep", n_cnv_r - c0, 0);

    run = 0;
    pulse(1);
    for (int t = 0; t < 500 && asleep; t++) tick(1);
    tick(2*DIV);
    check(!asleep, "R7 asleep cleared", asleep, 0);
    check(n_sck_r - s0 == 1, "R7 one sck pulse", n_sck_r - s0, 1);
    check(n_cnv_r == c0 && !msleep, "R7 no cnv on wake", n_cnv_r - c0, 0);

    run = 1;
    wait_valid(ok);
    check(ok && result == EXTRA[11:0], "R7 frames resume", result, EXTRA[11:0]);
    run = 0;
    c0 = n_cnv_r; v0 = n_valid;
    tick(200);
    check(n_cnv_r == c0 && n_valid == v0, "R10 stops at boundary", n_cnv_r - c0, 0);

    run = 1;
    for (int t = 0; t < 200 && n_cnv_r == c0; t++) tick(1);
    run = 0;
    wait_valid(ok);
    check(ok && result == EXTRA[11:0], "R10 started frame completes", ok, 1);
    c0 = n_cnv_r; s0 = n_sck_r;
    pulse(1);
    tick(100);
    check(n_sck_r == s0 && n_cnv_r == c0, "R7 wake ignored while awake", n_sck_r - s0, 0);

    run = 1;
    tick(30);
    rst_n = 0;
    tick(1);
    check({adc_sck, adc_cnv, result, ref_flag, result_valid, ref_not_ready, asleep} == '0,
          "R9 reset mid-run", result, 0);
    summary();
  end
endmodule